// File: doc/BRIEF.md
# Digital Receiver Presence Detector

This block turns the lock status of a digital audio receiver into a jack-style presence bit for a pin sense register. The raw lock level comes from another clock domain. It passes through a flip-flop synchronizer, and its rising and falling edges are captured in two sticky flags. Status reads clear those flags, one clear strobe for each flag.

Presence is reported only when four conditions hold together: the receiver's input converter is enabled, the converter and the receiver pin are both in the fully-on power state, the synchronized lock level is high, and the receiver has been enabled for enough received frames that its lock indication can be trusted. A settle counter counts per-frame strobes from the moment of enable. Any drop of enable restarts it. Each toggle of the presence bit also raises a one-cycle change event for notification logic. All pins are plain level or strobe signals, so there is no back-pressure at any edge of the block.

Top module: `rx_presence_detect`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `lock_flag`, `unlock_flag`, `present` and `present_chg` are all 0.
- R2: `lock_raw` passes through a two-stage synchronizer. A change of `lock_raw` set up before clock edge k first shows on `lock_flag`, `unlock_flag` or `present` at edge k+2, and no earlier.
- R3: `lock_flag` is set by a 0-to-1 transition of the synchronized lock level. It then stays at 1 until a cycle with `clr_lock` high and no new rising transition. When a clear and a new rising transition fall in the same cycle, the flag stays set.
- R4: `unlock_flag` is set by a 1-to-0 transition of the synchronized lock level. It follows the same rules as R3 with `clr_unlock`, including set winning over clear.
- R5: Each clear strobe affects only its own flag. `clr_lock` never changes `unlock_flag`, and `clr_unlock` never changes `lock_flag`.
- R6: `present` is a registered bit, equal one clock later to: `conv_en` AND `conv_pwr == 2'b00` AND `pin_pwr == 2'b00` AND synchronized lock AND settled. The encoding 2'b00 means fully on; 2'b01, 2'b10 and 2'b11 are the lower-power states.
- R7: The settle count goes up by one on each clock with `conv_en` and `frame_stb` both high, and stops at SETTLE_FRAMES (default 200). It is forced to 0 on any clock with `conv_en` low. "Settled" means the count equals SETTLE_FRAMES, so 199 strobes after enable give no presence and the 200th does.
- R8: `present_chg` is high for exactly one clock in each cycle where `present` differs from its value in the previous cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_raw | input | 1 | Receiver lock level, asynchronous |
| conv_en | input | 1 | Input converter enable |
| conv_pwr | input | 2 | Input converter power state (00 = fully on) |
| pin_pwr | input | 2 | Receiver pin power state (00 = fully on) |
| frame_stb | input | 1 | One-clock pulse per received frame |
| clr_lock | input | 1 | Clear strobe for the lock flag |
| clr_unlock | input | 1 | Clear strobe for the unlock flag |
| lock_flag | output | 1 | Sticky rising-lock flag |
| unlock_flag | output | 1 | Sticky falling-lock flag |
| present | output | 1 | Qualified presence-detect bit |
| present_chg | output | 1 | One-clock pulse on each toggle of `present` |

## Verification
The hardest case to reach from the ports is a clear strobe arriving in the same cycle as a new lock edge. The edge exists only inside the synchronizer, two clocks after the raw change. The stimulus sets `lock_raw`, waits two rising edges, and then raises the clear strobe for exactly the cycle in which the edge is registered. The settle boundary is approached by counting exactly 199 and then 200 frame strobes. After that, every combination of enable, both power states and lock level is swept, while a per-cycle monitor compares the change pulse against the observed toggles of the presence bit.

// File: rtl/rxpd_pkg.sv
package rxpd_pkg;
  typedef enum logic [1:0] {
    PWR_FULL  = 2'b00,
    PWR_LOW1  = 2'b01,
    PWR_LOW2  = 2'b10,
    PWR_LOW3  = 2'b11
  } pwr_state_e;

  function automatic logic pwr_is_full(input logic [1:0] st);
    return st == PWR_FULL;
  endfunction
endpackage

// File: rtl/rxpd_sync.sv
module rxpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxpd_settle.sv
module rxpd_settle #(
  parameter int FRAMES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(FRAMES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FRAMES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) cnt <= '0;
    else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);
endmodule

// File: rtl/rxpd_sticky.sv
module rxpd_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr_ev) flag <= 1'b0;
  end
endmodule

// File: rtl/rx_presence_detect.sv
module rx_presence_detect #(
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_FRAMES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_raw,
  input  logic       conv_en,
  input  logic [1:0] conv_pwr,
  input  logic [1:0] pin_pwr,
  input  logic       frame_stb,
  input  logic       clr_lock,
  input  logic       clr_unlock,
  output logic       lock_flag,
  output logic       unlock_flag,
  output logic       present,
  output logic       present_chg
);
  import rxpd_pkg::*;

  logic lock_sync;
  logic lock_prev;
  logic rise_ev;
  logic fall_ev;
  logic settled;
  logic pwr_ok;
  logic present_nxt;

  rxpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lock_raw), .q(lock_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) lock_prev <= 1'b0;
    else        lock_prev <= lock_sync;
  end

  assign rise_ev = lock_sync & ~lock_prev;
  assign fall_ev = ~lock_sync & lock_prev;

  rxpd_sticky u_lock_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(rise_ev), .clr_ev(clr_lock), .flag(lock_flag)
  );

  rxpd_sticky u_unlock_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(fall_ev), .clr_ev(clr_unlock), .flag(unlock_flag)
  );

  rxpd_settle #(.FRAMES(SETTLE_FRAMES)) u_settle (
    .clk(clk), .rst_n(rst_n), .enable(conv_en), .tick(frame_stb), .done(settled)
  );

  assign pwr_ok      = pwr_is_full(conv_pwr) & pwr_is_full(pin_pwr);
  assign present_nxt = conv_en & pwr_ok & settled & lock_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present     <= 1'b0;
      present_chg <= 1'b0;
    end else begin
      present     <= present_nxt;
      present_chg <= present_nxt ^ present;
    end
  end
endmodule

// File: rtl/rx_presence_checker.sv
module rx_presence_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       lock_s,
  input logic       settled,
  input logic       conv_en,
  input logic [1:0] conv_pwr,
  input logic [1:0] pin_pwr,
  input logic       clr_lock,
  input logic       clr_unlock,
  input logic       lock_flag,
  input logic       unlock_flag,
  input logic       present,
  input logic       present_chg
);
  p_lock_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_s) |=> lock_flag);
  p_lock_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lock && !$rose(lock_s)) |=> !lock_flag);
  p_unlock_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_s) |=> unlock_flag);
  p_unlock_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_unlock && !$fell(lock_s)) |=> !unlock_flag);
  p_pwr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_pwr != 2'b00 || pin_pwr != 2'b00 || !conv_en) |=> !present);
  p_settle_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |=> !present);
  p_chg_on_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(present) |-> present_chg);
  p_chg_only_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    present_chg |-> !$stable(present));
endmodule

bind rx_presence_detect rx_presence_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lock_s(lock_sync), .settled(settled),
  .conv_en(conv_en), .conv_pwr(conv_pwr), .pin_pwr(pin_pwr),
  .clr_lock(clr_lock), .clr_unlock(clr_unlock),
  .lock_flag(lock_flag), .unlock_flag(unlock_flag),
  .present(present), .present_chg(present_chg)
);

// File: tb/tb_rx_presence_detect.sv
`timescale 1ns/1ps
module tb_rx_presence_detect;
  localparam int SETTLE = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_raw = 1'b0, conv_en = 1'b0, frame_stb = 1'b0;
  logic clr_lock = 1'b0, clr_unlock = 1'b0;
  logic [1:0] conv_pwr = 2'b00, pin_pwr = 2'b00;
  logic lock_flag, unlock_flag, present, present_chg;

  int checks = 0;
  int fails = 0;
  logic mon_on = 1'b0;
  logic prev_present = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  rx_presence_detect #(.SETTLE_FRAMES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw), .conv_en(conv_en),
    .conv_pwr(conv_pwr), .pin_pwr(pin_pwr), .frame_stb(frame_stb),
    .clr_lock(clr_lock), .clr_unlock(clr_unlock), .lock_flag(lock_flag),
    .unlock_flag(unlock_flag), .present(present), .present_chg(present_chg)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      @(negedge clk);
    end
  endtask

  // R8 monitor: change pulse must match observed toggles every cycle
  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (present_chg !== (present ^ prev_present)) begin
        fails++;
        $display("FAIL R8: actual %b expected %b at %0t",
                 present_chg, present ^ prev_present, $time);
      end
    end
    prev_present <= present;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    lock_raw = 1'b1;
    ticks(4);
    // R1: reset state
    chk("R1 lock_flag", lock_flag, 1'b0);
    chk("R1 unlock_flag", unlock_flag, 1'b0);
    chk("R1 present", present, 1'b0);
    chk("R1 present_chg", present_chg, 1'b0);
    lock_raw = 1'b0;
    ticks(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", lock_flag | unlock_flag | present | present_chg, 1'b0);
    mon_on = 1'b1;

    // R2: latency through synchronizer
    lock_raw = 1'b1;            // set up before edge k
    @(negedge clk);             // after edge k
    chk("R2 edge k", lock_flag, 1'b0);
    @(negedge clk);             // after edge k+1
    chk("R2 edge k+1", lock_flag, 1'b0);
    @(negedge clk);             // after edge k+2
    chk("R2 edge k+2", lock_flag, 1'b1);
    // R3: flag holds
    ticks(5);
    chk("R3 hold", lock_flag, 1'b1);
    // R5: clr_unlock does not touch lock_flag
    clr_unlock = 1'b1; @(negedge clk); clr_unlock = 1'b0; @(negedge clk);
    chk("R5 lock kept", lock_flag, 1'b1);
    clr_lock = 1'b1; @(negedge clk); clr_lock = 1'b0; @(negedge clk);
    chk("R3 clear", lock_flag, 1'b0);
    // R4: falling edge
    lock_raw = 1'b0; ticks(3);
    chk("R4 set", unlock_flag, 1'b1);
    chk("R3 no set on fall", lock_flag, 1'b0);
    clr_lock = 1'b1; @(negedge clk); clr_lock = 1'b0; @(negedge clk);
    chk("R5 unlock kept", unlock_flag, 1'b1);
    clr_unlock = 1'b1; @(negedge clk); clr_unlock = 1'b0; @(negedge clk);
    chk("R4 clear", unlock_flag, 1'b0);

    // R3: set wins over simultaneous clear
    lock_raw = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    clr_lock = 1'b1;
    @(negedge clk);
    clr_lock = 1'b0;
    chk("R3 set wins", lock_flag, 1'b1);
    // R4: set wins over simultaneous clear
    lock_raw = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    clr_unlock = 1'b1;
    @(negedge clk);
    clr_unlock = 1'b0;
    chk("R4 set wins", unlock_flag, 1'b1);

    // R7: settle boundary
    lock_raw = 1'b1; ticks(3);
    conv_en = 1'b1;
    strobes(SETTLE - 1);
    ticks(3);
    chk("R7 199 frames", present, 1'b0);
    strobes(1);
    ticks(1);
    chk("R7 200 frames", present, 1'b1);
    strobes(5);
    chk("R7 saturate", present, 1'b1);
    // R7: restart on enable drop
    conv_en = 1'b0; ticks(2);
    chk("R6 enable off", present, 1'b0);
    conv_en = 1'b1;
    strobes(100);
    ticks(2);
    chk("R7 restart", present, 1'b0);
    strobes(SETTLE - 100);
    ticks(2);
    chk("R7 resettled", present, 1'b1);

    // R6: sweep enabled combos (counter stays settled while enabled)
    for (int cp = 0; cp < 4; cp++)
      for (int pp = 0; pp < 4; pp++)
        for (int lk = 0; lk < 2; lk++) begin
          conv_pwr = 2'(cp); pin_pwr = 2'(pp); lock_raw = lk[0];
          ticks(4);
          chk("R6 sweep en", present, (cp == 0 && pp == 0 && lk == 1));
        end
    // R6: sweep with enable low
    conv_en = 1'b0;
    for (int cp = 0; cp < 4; cp++)
      for (int pp = 0; pp < 4; pp++)
        for (int lk = 0; lk < 2; lk++) begin
          conv_pwr = 2'(cp); pin_pwr = 2'(pp); lock_raw = lk[0];
          frame_stb = 1'b1;
          ticks(4);
          frame_stb = 1'b0;
          chk("R6 sweep dis", present, 1'b0);
        end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule